// File: doc/BRIEF.md
# Interrupt Sense Conversion Unit

This block sits in front of an interrupt controller whose inputs accept only two kinds of request: an active-high level or a rising edge. Each external interrupt line can be set to one of four sense modes. The block turns that line into the form the controller accepts. In low-level mode the line's inverted value is passed on as a level. In the three edge modes (falling, rising or both) every qualifying edge becomes a pulse that lasts one clock cycle.

The mode fields live in two 32-bit mode registers, one in each of two banks. The general bank holds the fields for fourteen ordinary lines. The safety bank holds the fields for two safety lines and for one system error line. Software sets the modes through a plain register port with a bank select and a byte offset. Sixteen software-triggered CPU interrupt sources are already synchronous to the clock. They use no mode field and are always treated as rising-edge sources.

External lines cross into the clock domain through a two-flop synchronizer. When software changes a mode field, the edge history of that line is reloaded, so the write itself can never create a request.

Top module: `irq_sense_conv`

## Requirements
- R1: A mode field is two bits wide: 00 selects low level, 01 falling edge, 10 rising edge and 11 both edges. Field i sits at bits [2i+1:2i] of the 32-bit mode register at byte offset 0x0C of its bank.
- R2: reg_sel_i = 0 addresses the general bank, whose fields 0 to 13 control ext_ns lines 0 to 13. reg_sel_i = 1 addresses the safety bank, whose fields 0 and 1 control ext_sf lines 0 and 1 and whose field 2 controls the error line. Writing one bank leaves the other bank unchanged.
- R3: Both mode registers reset to zero, and a read returns the last value written. A write to any other offset is ignored, and a read of any other offset returns zero.
- R4: In low-level mode the output equals the inverted input. A change at the input shows at the output after the third rising clock edge that follows it.
- R5: In falling-edge mode each 1-to-0 input transition produces an output pulse, and a 0-to-1 transition produces none. The pulse starts at the third rising edge after the transition.
- R6: In rising-edge mode each 0-to-1 input transition produces an output pulse, and a 1-to-0 transition produces none. The pulse has the same latency as in R5.
- R7: In both-edge mode every input transition produces an output pulse, with the same latency as in R5.
- R8: In every edge mode an output pulse is high for exactly one clock cycle, even while the input stays at its new level.
- R9: A write that changes a line's mode field reloads that line's edge history. No pulse results from the change, even if the input moved while the line was in low-level mode.
- R10: Each swi_i bit produces a one-cycle pulse on the matching swi_o bit, starting at the first rising edge after a 0-to-1 transition. A 1-to-0 transition produces no pulse.
- R11: After reset, with the external inputs held high and swi_i held low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Bank select: 0 general, 1 safety |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset within the bank |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| ext_ns_i | input | 14 | General external interrupt lines |
| ext_sf_i | input | 2 | Safety external interrupt lines |
| err_i | input | 1 | System error line |
| swi_i | input | 16 | Software CPU interrupt sources |
| ext_ns_o | output | 14 | Converted general lines |
| ext_sf_o | output | 2 | Converted safety lines |
| err_o | output | 1 | Converted error line |
| swi_o | output | 16 | Rising-edge pulses from the software sources |

## Verification
The hardest case to reach from the ports is a stale edge history. The line has to sit in low-level mode, where its history is frozen, while its input moves away from the stored value. Only then is it switched to an edge mode. The stimulus holds a line in low-level mode, drops its input, waits until the level output confirms the new value, and then writes falling-edge mode. It then watches several cycles for a pulse that must not come, and finally toggles the input to show that real edges still get through.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int unsigned FIELD_W = 2;

  typedef enum logic [FIELD_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

endpackage

// File: rtl/irq_mode_bank.sv
module irq_mode_bank
  import irq_sense_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h0C,
  parameter int unsigned NUM_FIELDS = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     mode_o,
  output logic [NUM_FIELDS-1:0] chg_o
);

  logic                  hit;
  logic                  mode_en;
  logic [DATA_W-1:0]     mode_q;
  logic [DATA_W-1:0]     mode_d;
  logic [NUM_FIELDS-1:0] chg_d;
  logic [NUM_FIELDS-1:0] chg_q;

  assign hit     = sel_i && (addr_i == MODE_OFS);
  assign mode_en = we_i && hit;

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = wdata_i;
  end

  // A field counts as changed only when its value really differs.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_chg
    assign chg_d[f] = mode_d[f*FIELD_W +: FIELD_W] != mode_q[f*FIELD_W +: FIELD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      chg_q  <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      chg_q <= chg_d;
    end
  end

  assign mode_o = mode_q;
  assign chg_o  = chg_q;

  // R3: the register holds its value unless it is written.
  p_hold_unless_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && hit) |=> $stable(mode_q));

  // R9: a change flag only follows a write to this bank.
  p_chg_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q != '0) |-> $past(we_i && hit));

endmodule

// File: rtl/irq_sense_chan.sv
module irq_sense_chan
  import irq_sense_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE        = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_i,
  input  sense_e mode_i,
  input  logic   reload_i,
  output logic   out_o
);

  logic s;
  logic prev_q;
  logic prev_en;
  logic fall;
  logic rise;
  logic out_d;
  logic out_q;

  if (SYNC_STAGES == 0) begin : g_nosync
    assign s = in_i;
  end else begin : g_sync
    localparam int unsigned SW = SYNC_STAGES;
    logic [SW-1:0] sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= {SW{IDLE}};
      end else begin
        sync_q[0] <= in_i;
        for (int k = 1; k < SW; k++) sync_q[k] <= sync_q[k-1];
      end
    end
    assign s = sync_q[SW-1];
  end

  // The edge history is frozen in level mode and reloaded when the mode changes.
  assign prev_en = reload_i || (mode_i != SENSE_LOW);
  assign fall    = prev_q && !s;
  assign rise    = !prev_q && s;

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  out_d = !s;
      SENSE_FALL: out_d = fall;
      SENSE_RISE: out_d = rise;
      SENSE_BOTH: out_d = fall || rise;
      default:    out_d = 1'b0;
    endcase
    if (reload_i && (mode_i != SENSE_LOW)) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
    end else if (prev_en) begin
      prev_q <= s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

  // R4: in level mode the output follows the inverted synchronized input.
  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LOW) |=> (out_q == !$past(s)));

  // R8: an edge pulse never lasts two cycles.
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && (mode_i != SENSE_LOW)) |=> (!out_q || (mode_i == SENSE_LOW)));

  // R9: the reload cycle produces no pulse.
  p_reload_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && (mode_i != SENSE_LOW)) |=> !out_q);

  // R5: in edge modes a pulse needs a difference between history and input.
  p_edge_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != SENSE_LOW) |=> (!out_q || $past(prev_q != s)));

endmodule

// File: rtl/irq_sense_conv.sv
module irq_sense_conv
  import irq_sense_pkg::*;
#(
  parameter int unsigned NS_LINES    = 14,
  parameter int unsigned SF_LINES    = 2,
  parameter int unsigned SWI_LINES   = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h0C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NS_LINES-1:0]  ext_ns_i,
  input  logic [SF_LINES-1:0]  ext_sf_i,
  input  logic                 err_i,
  input  logic [SWI_LINES-1:0] swi_i,
  output logic [NS_LINES-1:0]  ext_ns_o,
  output logic [SF_LINES-1:0]  ext_sf_o,
  output logic                 err_o,
  output logic [SWI_LINES-1:0] swi_o
);

  localparam int unsigned ERR_FIELD = SF_LINES;
  localparam int unsigned SF_FIELDS = SF_LINES + 1;

  logic [DATA_W-1:0]    ns_mode;
  logic [DATA_W-1:0]    sf_mode;
  logic [NS_LINES-1:0]  ns_chg;
  logic [SF_FIELDS-1:0] sf_chg;

  irq_mode_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .NUM_FIELDS(NS_LINES)
  ) u_bank_ns (
    .clk(clk), .rst_n(rst_n), .sel_i(!reg_sel_i), .we_i(reg_we_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .mode_o(ns_mode), .chg_o(ns_chg)
  );

  irq_mode_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .NUM_FIELDS(SF_FIELDS)
  ) u_bank_sf (
    .clk(clk), .rst_n(rst_n), .sel_i(reg_sel_i), .we_i(reg_we_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .mode_o(sf_mode), .chg_o(sf_chg)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == MODE_OFS) reg_rdata_o = reg_sel_i ? sf_mode : ns_mode;
  end

  for (genvar i = 0; i < NS_LINES; i++) begin : g_ns
    irq_sense_chan #(.SYNC_STAGES(SYNC_STAGES), .IDLE(1'b1)) u_chan (
      .clk(clk), .rst_n(rst_n), .in_i(ext_ns_i[i]),
      .mode_i(sense_e'(ns_mode[i*FIELD_W +: FIELD_W])),
      .reload_i(ns_chg[i]), .out_o(ext_ns_o[i])
    );
  end

  for (genvar i = 0; i < SF_LINES; i++) begin : g_sf
    irq_sense_chan #(.SYNC_STAGES(SYNC_STAGES), .IDLE(1'b1)) u_chan (
      .clk(clk), .rst_n(rst_n), .in_i(ext_sf_i[i]),
      .mode_i(sense_e'(sf_mode[i*FIELD_W +: FIELD_W])),
      .reload_i(sf_chg[i]), .out_o(ext_sf_o[i])
    );
  end

  irq_sense_chan #(.SYNC_STAGES(SYNC_STAGES), .IDLE(1'b1)) u_err (
    .clk(clk), .rst_n(rst_n), .in_i(err_i),
    .mode_i(sense_e'(sf_mode[ERR_FIELD*FIELD_W +: FIELD_W])),
    .reload_i(sf_chg[ERR_FIELD]), .out_o(err_o)
  );

  for (genvar i = 0; i < SWI_LINES; i++) begin : g_swi
    irq_sense_chan #(.SYNC_STAGES(0), .IDLE(1'b0)) u_chan (
      .clk(clk), .rst_n(rst_n), .in_i(swi_i[i]), .mode_i(SENSE_RISE),
      .reload_i(1'b0), .out_o(swi_o[i])
    );

    // R10: a software pulse needs the source high at the previous edge.
    p_swi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      swi_o[i] |-> $past(swi_i[i]));
  end

endmodule

// File: tb/irq_sense_conv_tb.sv
module irq_sense_conv_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS_MODE = 8'h0C;
  localparam logic [1:0] T_NS = 2'd0, T_SF = 2'd1, T_ER = 2'd2;
  localparam int NVEC = 13;
  // {target[1:0], index[3:0], mode[1:0], start, end, pulse expected}
  localparam logic [10:0] VEC [NVEC] = '{
    {T_NS, 4'd5,  2'b01, 1'b1, 1'b0, 1'b1},
    {T_NS, 4'd5,  2'b01, 1'b0, 1'b1, 1'b0},
    {T_NS, 4'd5,  2'b10, 1'b0, 1'b1, 1'b1},
    {T_NS, 4'd5,  2'b10, 1'b1, 1'b0, 1'b0},
    {T_NS, 4'd13, 2'b11, 1'b0, 1'b1, 1'b1},
    {T_NS, 4'd13, 2'b11, 1'b1, 1'b0, 1'b1},
    {T_NS, 4'd0,  2'b00, 1'b1, 1'b0, 1'b0},
    {T_SF, 4'd0,  2'b10, 1'b0, 1'b1, 1'b1},
    {T_SF, 4'd1,  2'b01, 1'b1, 1'b0, 1'b1},
    {T_ER, 4'd0,  2'b11, 1'b1, 1'b0, 1'b1},
    {T_ER, 4'd0,  2'b00, 1'b0, 1'b1, 1'b0},
    {T_SF, 4'd1,  2'b00, 1'b1, 1'b0, 1'b0},
    {T_NS, 4'd9,  2'b01, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [13:0] ns_in, ns_out;
  logic [1:0]  sf_in, sf_out;
  logic        er_in, er_out;
  logic [15:0] swi_in, swi_out;
  logic [31:0] ns_shadow, sf_shadow;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sense_conv u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ext_ns_i(ns_in), .ext_sf_i(sf_in), .err_i(er_in), .swi_i(swi_in),
    .ext_ns_o(ns_out), .ext_sf_o(sf_out), .err_o(er_out), .swi_o(swi_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] a, input logic [31:0] d);
    reg_sel = sel; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] a, output logic [31:0] d);
    reg_sel = sel; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_mode(input logic [1:0] t, input int idx, input logic [1:0] m);
    int f;
    if (t == T_NS) begin
      ns_shadow[2*idx +: 2] = m;
      wr(1'b0, OFS_MODE, ns_shadow);
    end else begin
      f = (t == T_ER) ? 2 : idx;
      sf_shadow[2*f +: 2] = m;
      wr(1'b1, OFS_MODE, sf_shadow);
    end
  endtask

  task automatic set_in(input logic [1:0] t, input int idx, input logic v);
    if (t == T_NS) ns_in[idx] = v;
    else if (t == T_SF) sf_in[idx] = v;
    else er_in = v;
  endtask

  function automatic logic out_of(input logic [1:0] t, input int idx);
    if (t == T_NS) return ns_out[idx];
    if (t == T_SF) return sf_out[idx];
    return er_out;
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int pulses;
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ns_in = '1; sf_in = '1; er_in = 1'b1; swi_in = '0;
    ns_shadow = '0; sf_shadow = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R11: reset state of all outputs; R3: registers reset to zero
    check("R11 outputs", {ns_out, sf_out, er_out}, '0);
    check("R11 swi", {16'h0, swi_out}, '0);
    rd(1'b0, OFS_MODE, d); check("R3 general reset", d, '0);
    rd(1'b1, OFS_MODE, d); check("R3 safety reset", d, '0);

    // R9: stale history in level mode must not fire after a switch to falling mode
    ns_in[6] = 1'b0;
    cyc(4);
    check("R4 level asserted", {31'h0, ns_out[6]}, 32'h1);
    set_mode(T_NS, 6, 2'b01);
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      if (ns_out[6]) pulses++;
    end
    check("R9 no pulse after mode change", pulses, 0);
    ns_in[6] = 1'b1; cyc(4);
    ns_in[6] = 1'b0; cyc(3);
    check("R9 real edge still detected", {31'h0, ns_out[6]}, 32'h1);
    cyc(1);

    // R1 R2 R4-R8: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] t, m;
      int idx;
      logic v0, v1, ep;
      {t, idx[3:0], m, v0, v1, ep} = VEC[v];
      idx = idx & 15;
      set_mode(t, idx, m);
      set_in(t, idx, v0);
      cyc(5);
      check({req_of(m), " idle"}, {31'h0, out_of(t, idx)}, (m == 2'b00) ? {31'h0, !v0} : 32'h0);
      set_in(t, idx, v1);
      cyc(2);
      check({req_of(m), " not early"}, {31'h0, out_of(t, idx)}, (m == 2'b00) ? {31'h0, !v0} : 32'h0);
      cyc(1);
      check({req_of(m), " R1 response"}, {31'h0, out_of(t, idx)}, (m == 2'b00) ? {31'h0, !v1} : {31'h0, ep});
      cyc(1);
      check((m == 2'b00) ? "R4 held" : "R8 one cycle", {31'h0, out_of(t, idx)},
            (m == 2'b00) ? {31'h0, !v1} : 32'h0);
    end

    // R2: banks are separate; the error field is field 2 of the safety bank
    rd(1'b0, OFS_MODE, d); check("R2 general bank", d, ns_shadow);
    rd(1'b1, OFS_MODE, d); check("R2 safety bank", d, sf_shadow);
    check("R2 error field position", {30'h0, d[5:4]}, {30'h0, sf_shadow[5:4]});

    // R3: writes elsewhere are ignored and read as zero
    wr(1'b0, 8'h10, 32'hFFFF_FFFF);
    rd(1'b0, OFS_MODE, d); check("R3 stray write ignored", d, ns_shadow);
    rd(1'b0, 8'h10, d); check("R3 other offset reads zero", d, '0);
    wr(1'b1, OFS_MODE, 32'hA5C3_0F96);
    rd(1'b1, OFS_MODE, d); check("R3 readback", d, 32'hA5C3_0F96);
    rd(1'b0, OFS_MODE, d); check("R2 other bank untouched", d, ns_shadow);

    // R10: software sources pulse on rising edge after one edge
    swi_in[7] = 1'b1;
    cyc(1); check("R10 swi pulse", {16'h0, swi_out}, 32'h0080);
    cyc(1); check("R10 swi one cycle", {16'h0, swi_out}, '0);
    swi_in[7] = 1'b0;
    cyc(1); check("R10 swi fall ignored", {16'h0, swi_out}, '0);
    swi_in[15] = 1'b1; swi_in[0] = 1'b1;
    cyc(1); check("R10 swi two sources", {16'h0, swi_out}, 32'h8001);
    cyc(1); check("R10 swi held high", {16'h0, swi_out}, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule